// File: doc/BRIEF.md
# Six-Channel Down-Counting Interval Timer

The block holds a bank of independent down-counting timers. Software reaches them through a flat word-addressed register bus: a write strobe with address and data, and a read port whose data follows the address combinationally.

Each channel has four parts:
- a control register;
- a reload interval register;
- a current-count register that software may write at any time;
- a free-running prescaler that divides a shared oscillator tick enable by a power of two.

When a channel's count runs out, the channel sets its bit in a shared pending register. The count then either reloads from the interval register or stops at zero. A single interrupt line is raised while any pending channel is also enabled.

A typical use loads the current count with the first timeout and the interval register with the period. Software then sets start. Each expiry is acknowledged by writing a one to the matching pending bit.

Top module: `multi_interval_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Byte-address map:
  - 0x00 is interrupt enable and 0x04 is pending, with bit n belonging to channel n.
  - Channel n has control at 0x10+0x10*n, interval at 0x14+0x10*n and current count at 0x18+0x10*n.
  - Control keeps bits 7:0 and reads zero above them. Any other address reads zero.
- R3: A channel counts when control bit 0 (start) is 1 and bits 3:2 (source) equal 01. It decrements once per prescaled tick. A tick that finds the count at 1 or 0 is an expiry, so a count of N expires N prescaled ticks after start is set.
- R4: Control bits 6:4 hold p, and the channel steps on every 2^p-th `tick_in` cycle. The prescaler count restarts from zero whenever start goes from 0 to 1.
- R5: Periodic behaviour applies when bit 1 (auto-reload) is 1 and bit 7 (single) is 0. At expiry the count loads the interval value and start stays 1, giving a period of interval*2^p ticks.
- R6: One-shot behaviour applies when auto-reload is 0 or single is 1. At expiry the count becomes 0 and start clears.
- R7: Expiry sets the channel's pending bit. Writing 1 to a pending bit clears it, and writing 0 leaves it unchanged.
- R8: If an expiry and a write-one-clear hit the same pending bit in one cycle, the bit ends up set.
- R9: `irq` is high exactly when some channel has both its pending bit and its enable bit set.
- R10: While `tick_in` is low, or the source field is not 01, the count does not change.
- R11: A write to the current-count register of a running channel takes priority over that cycle's decrement. It sets the count from which the next expiry is timed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 8 | Register byte address |
| wr_en | input | 1 | Write strobe, one word per cycle |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| tick_in | input | 1 | Oscillator tick enable |
| irq | output | 1 | Combined interrupt |

## Verification
A register write takes effect at the edge it is presented on, and read data is valid in the same cycle, so every read is taken half a cycle after the edge. With `tick_in` held high, a channel started with count N and prescaler p expires exactly N*2^p edges after the start write. Its pending bit and status are checked one cycle before that edge and again just after it. For every other result the bench counts the edges from the relevant write in the same way, across a sweep of counts 1 to 4 and prescalers 0 to 3 spread over all channels.

// File: rtl/multi_interval_timer.sv
module multi_interval_timer #(
  parameter int NCH = 6,
  parameter int W   = 32,
  parameter int AW  = 8,
  parameter int PW  = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata,
  input  logic          tick_in,
  output logic          irq
);
  localparam int PCW = (1 << PW) - 1;

  logic [NCH-1:0] ien, pend, expire;
  logic [7:0]     ctl  [NCH];
  logic [W-1:0]   ival [NCH];
  logic [W-1:0]   cur  [NCH];
  logic [PCW-1:0] pcnt [NCH];

  wire ien_we  = wr_en && addr == AW'(0);
  wire pend_we = wr_en && addr == AW'(4);
  wire [NCH-1:0] clr = pend_we ? wdata[NCH-1:0] : '0;

  assign irq = |(pend & ien);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ien  <= '0;
      pend <= '0;
    end else begin
      if (ien_we) ien <= wdata[NCH-1:0];
      pend <= (pend & ~clr) | expire;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic ctl_we, ival_we, cur_we, run, step, reload;
    assign ctl_we  = wr_en && addr == AW'(16 + 16*i);
    assign ival_we = wr_en && addr == AW'(20 + 16*i);
    assign cur_we  = wr_en && addr == AW'(24 + 16*i);
    assign run     = ctl[i][0] && ctl[i][3:2] == 2'b01;
    assign step    = run && tick_in &&
                     pcnt[i] == (PCW'(1) << ctl[i][6:4]) - PCW'(1);
    assign expire[i] = step && cur[i] <= W'(1);
    assign reload  = ctl[i][1] && !ctl[i][7];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        ctl[i]  <= '0;
        ival[i] <= '0;
        cur[i]  <= '0;
        pcnt[i] <= '0;
      end else begin
        if (!ctl[i][0])          pcnt[i] <= '0;
        else if (run && tick_in) pcnt[i] <= step ? '0 : pcnt[i] + PCW'(1);

        if (ctl_we)                    ctl[i]    <= wdata[7:0];
        else if (expire[i] && !reload) ctl[i][0] <= 1'b0;

        if (ival_we) ival[i] <= wdata;

        if (cur_we)         cur[i] <= wdata;
        else if (expire[i]) cur[i] <= reload ? ival[i] : '0;
        else if (step)      cur[i] <= cur[i] - W'(1);
      end
    end

    p_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && cur[i] > W'(1) && !cur_we) |=> cur[i] == $past(cur[i]) - W'(1));
    p_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ((!tick_in || ctl[i][3:2] != 2'b01) && !cur_we) |=> $stable(cur[i]));
    p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && reload && !ctl_we && !cur_we && !ival_we)
        |=> (ctl[i][0] && cur[i] == $past(ival[i])));
    p_oneshot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (expire[i] && !reload && !ctl_we && !cur_we) |=> (!ctl[i][0] && cur[i] == '0));
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
      expire[i] |=> pend[i]);
    p_w1c_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_we && wdata[i] && !expire[i]) |=> !pend[i]);
  end

  always_comb begin
    rdata = '0;
    if (addr == AW'(0)) rdata = W'(ien);
    if (addr == AW'(4)) rdata = W'(pend);
    for (int i = 0; i < NCH; i++) begin
      if (addr == AW'(16 + 16*i)) rdata = W'(ctl[i]);
      if (addr == AW'(20 + 16*i)) rdata = ival[i];
      if (addr == AW'(24 + 16*i)) rdata = cur[i];
    end
  end
endmodule

// File: tb/sim_multi_interval_timer.sv
module sim_multi_interval_timer;
  logic        clk = 0, rst_n = 0, wr_en = 0, tick_in = 1;
  logic [7:0]  addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic        irq;
  int total = 0, bad = 0;

  multi_interval_timer u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .tick_in(tick_in), .irq(irq));

  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] v);
    addr = a; #1; v = rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] ca(input int ch, input int k);
    return 8'(16 + 16*ch + 4*k);
  endfunction

  initial begin
    #2000000;
    bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    cyc(3); rst_n = 1; cyc(1);

    // R1 reset values
    rd(0, v); chk("R1 ien", v, 0);
    rd(4, v); chk("R1 pend", v, 0);
    for (int c = 0; c < 6; c++)
      for (int k = 0; k < 3; k++) begin rd(ca(c, k), v); chk("R1 chan", v, 0); end
    chk("R1 irq", {31'd0, irq}, 0);

    // R2 map and readback
    wr(0, 32'h3F); rd(0, v); chk("R2 ien", v, 32'h3F);
    wr(0, 0);
    wr(ca(5,0), 32'hA4); rd(ca(5,0), v); chk("R2 ctl5", v, 32'hA4);
    wr(ca(2,1), 32'h1234_5678); rd(ca(2,1), v); chk("R2 ival2", v, 32'h1234_5678);
    wr(ca(3,2), 32'hCAFE_0001); rd(ca(3,2), v); chk("R2 cur3", v, 32'hCAFE_0001);
    wr(ca(4,0), 32'hFFFF_FFFF); rd(ca(4,0), v); chk("R2 ctl4 width", v, 32'hFF);
    rd(8'h08, v); chk("R2 unmapped", v, 0);
    rd(8'h1C, v); chk("R2 unmapped", v, 0);
    wr(ca(4,0), 0); wr(ca(5,0), 0); wr(4, 32'h3F);

    // R3 R4 R6 sweep of count and prescaler, one-shot via single bit
    for (int p = 0; p < 4; p++)
      for (int n = 1; n <= 4; n++) begin
        int c, d;
        logic [7:0] cw;
        c = (p*4 + n) % 6; d = 1 << p;
        cw = 8'h85 | 8'(p << 4);
        wr(4, 32'h3F);
        wr(ca(c,2), n);
        wr(ca(c,0), cw);
        cyc(n*d - 1);
        rd(4, v);      chk("R3 not yet", v[c], 0);
        rd(ca(c,2), v); chk("R4 cur before", v, 1);
        cyc(1);
        rd(4, v);      chk("R3 expired", v[c], 1);
        rd(ca(c,2), v); chk("R6 cur zero", v, 0);
        rd(ca(c,0), v); chk("R6 start clr", v, 32'(cw & 8'hFE));
        chk("R9 no enable", {31'd0, irq}, 0);
      end
    wr(4, 32'h3F);

    // R5 periodic: interval 3, first count 2, prescale 2
    wr(ca(1,1), 3); wr(ca(1,2), 2); wr(ca(1,0), 32'h17);
    cyc(3); rd(4, v); chk("R5 first early", v[1], 0);
    cyc(1); rd(4, v); chk("R5 first", v[1], 1);
    rd(ca(1,2), v); chk("R5 reload", v, 3);
    rd(ca(1,0), v); chk("R5 still on", v, 32'h17);
    wr(4, 32'h2);
    cyc(4); rd(4, v); chk("R5 period early", v[1], 0);
    rd(ca(1,2), v); chk("R5 cur mid", v, 1);
    cyc(1); rd(4, v); chk("R5 period", v[1], 1);
    wr(ca(1,0), 0);

    // R7 write-zero no effect, write-one clears
    wr(4, 0); rd(4, v); chk("R7 zero write", v[1], 1);
    // R9 irq
    chk("R9 disabled", {31'd0, irq}, 0);
    wr(0, 32'h2); chk("R9 enabled", {31'd0, irq}, 1);
    wr(0, 32'h1); chk("R9 other", {31'd0, irq}, 0);
    wr(4, 32'h2); rd(4, v); chk("R7 clear", v[1], 0);
    wr(0, 0);

    // R8 clear in the expiry cycle
    wr(ca(2,2), 3); wr(ca(2,0), 32'h85);
    cyc(2); wr(4, 32'h4);
    rd(4, v); chk("R8 set wins", v[2], 1);
    wr(4, 32'h3F);

    // R10 freeze
    wr(ca(3,2), 5); wr(ca(3,0), 32'h01);
    cyc(4); rd(ca(3,2), v); chk("R10 bad source", v, 5);
    tick_in = 0; wr(ca(3,0), 32'h05);
    cyc(4); rd(ca(3,2), v); chk("R10 no tick", v, 5);
    tick_in = 1; cyc(2);
    rd(ca(3,2), v); chk("R10 resumes", v, 3);
    wr(ca(3,0), 0);

    // R11 reload current count while running
    wr(ca(4,2), 20); wr(ca(4,0), 32'h05);
    cyc(3); rd(ca(4,2), v); chk("R3 running", v, 17);
    wr(ca(4,2), 2);
    cyc(1); rd(4, v); chk("R11 early", v[4], 0);
    rd(ca(4,2), v); chk("R11 cur", v, 1);
    cyc(1); rd(4, v); chk("R11 expiry", v[4], 1);
    wr(4, 32'h3F);

    // R4 prescaler restart on start
    wr(ca(0,2), 2); wr(ca(0,0), 32'hA5);
    cyc(1); wr(ca(0,0), 32'hA4); cyc(2);
    wr(ca(0,0), 32'hA5);
    cyc(7); rd(4, v); chk("R4 restart early", v[0], 0);
    cyc(1); rd(4, v); chk("R4 restart", v[0], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule